// File: doc/BRIEF.md
# Cycle-Stealing Block Transfer Engine

This block copies a run of words between a single peripheral and memory so that the processor never handles the data itself. Software sets up the transfer with writes through a small register port. It gives the direction, the peripheral address, the first memory address and the number of words, then sets a start bit. From that point the engine runs alone. For each word it waits until the peripheral is able to take part, asks for the system bus, makes exactly one memory access and gives the bus back. The processor is never interrupted during a word. At worst it waits at its next bus access while one word is in flight.

Once the last word has moved, the engine clears its busy flag and raises an interrupt. The interrupt stays high until software clears it. A start with a word count of zero finishes at once and never asks for the bus.

Top module: `dma_steal_top`

## Requirements
- R1: While reset is high and in the cycle after it is released, `busy`, `irq`, `bus_req`, `mem_valid` and `per_stb` are all low.
- R2: A register write with `cfg_sel`=1 sets the peripheral address, 2 sets the first memory address and 3 sets the word count. `cfg_sel`=0 is the control write: bit 0 starts a transfer, bit 1 gives the direction and bit 2 clears the interrupt. While `busy` is high, writes with selects 1 to 3 and start requests have no effect.
- R3: `bus_req` rises only in the cycle after `per_rdy` was sampled high while the engine was waiting for the peripheral. While `per_rdy` stays low, `bus_req` stays low.
- R4: Once raised, `bus_req` holds until `bus_gnt` is sampled high. `mem_valid` rises in the next cycle. While `mem_ready` is low, `mem_valid`, `mem_addr`, `mem_we` and `mem_wdata` hold steady.
- R5: Each grant carries exactly one word. In the cycle after `mem_ready` is sampled high, `bus_req` and `mem_valid` are low and `per_stb` is high for that one cycle.
- R6: Direction 0 moves data from the peripheral to memory. In that case `mem_we` is 1 and `mem_wdata` is the `per_rdata` sampled at the grant. Direction 1 moves data from memory to the peripheral. In that case `mem_we` is 0 and `per_wdata` holds the `mem_rdata` sampled with `mem_ready` while `per_stb` is high.
- R7: Word k of a transfer uses memory address start+k, and exactly the programmed number of words is moved.
- R8: In the same cycle as the strobe of the last word, `busy` goes low and `irq` goes high. Before that, `busy` stays high.
- R9: `irq` stays high until a control write with bit 2 set. If that write arrives in the same cycle in which a transfer completes, `irq` ends up high.
- R10: A start with a word count of zero sets `irq` in the next cycle. It leaves `busy` low and never raises `bus_req`.
- R11: `per_addr` shows the programmed peripheral address for the whole transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select |
| cfg_wdata | input | DW | Register write data |
| busy | output | 1 | Transfer in progress |
| irq | output | 1 | Completion interrupt |
| bus_req | output | 1 | Bus request |
| bus_gnt | input | 1 | Bus grant |
| mem_valid | output | 1 | Memory access valid |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data |
| mem_ready | input | 1 | Memory access accepted |
| per_addr | output | PAW | Peripheral address |
| per_rdy | input | 1 | Peripheral has data or room |
| per_rdata | input | DW | Data from the peripheral |
| per_wdata | output | DW | Data to the peripheral |
| per_stb | output | 1 | One-cycle word-done strobe |

## Verification
The clear of the interrupt by software and the setting of the interrupt by completion can fall on the same clock edge. The bench provokes this by watching for the cycle in which the memory model raises `mem_ready` on the final word, and placing a clear write in that same cycle. Completion must win, so `irq` is checked high afterwards and low again only after a later clear on its own. A zero-count start combined with a clear in one control write tests the same collision without any bus traffic.

// File: rtl/dma_steal_pkg.sv
package dma_steal_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_REQ,
    ST_XFER,
    ST_REL
  } steal_state_t;

  localparam logic [1:0] SEL_CTRL  = 2'd0;
  localparam logic [1:0] SEL_PADDR = 2'd1;
  localparam logic [1:0] SEL_MADDR = 2'd2;
  localparam logic [1:0] SEL_COUNT = 2'd3;

  localparam int CTL_START = 0;
  localparam int CTL_DIR   = 1;
  localparam int CTL_CLR   = 2;

  localparam logic DIR_TO_MEM   = 1'b0;
  localparam logic DIR_FROM_MEM = 1'b1;

endpackage

// File: rtl/dma_cfg_regs.sv
module dma_cfg_regs
  import dma_steal_pkg::*;
#(
  parameter int DW  = 16,
  parameter int AW  = 16,
  parameter int PAW = 8,
  parameter int CW  = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_sel,
  input  logic [DW-1:0] cfg_wdata,
  input  logic          busy,
  output logic          dir_q,
  output logic [PAW-1:0] paddr_q,
  output logic [AW-1:0] maddr_q,
  output logic [CW-1:0] count_q,
  output logic          start_req,
  output logic          clr_req
);

  logic ctrl_wr;
  logic open_wr;

  assign ctrl_wr   = cfg_we && (cfg_sel == SEL_CTRL);
  assign open_wr   = cfg_we && !busy;
  assign start_req = ctrl_wr && cfg_wdata[CTL_START] && !busy;
  assign clr_req   = ctrl_wr && cfg_wdata[CTL_CLR];

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q   <= DIR_TO_MEM;
      paddr_q <= '0;
      maddr_q <= '0;
      count_q <= '0;
    end else if (open_wr) begin
      case (cfg_sel)
        SEL_CTRL:  if (cfg_wdata[CTL_START]) dir_q <= cfg_wdata[CTL_DIR];
        SEL_PADDR: paddr_q <= cfg_wdata[PAW-1:0];
        SEL_MADDR: maddr_q <= cfg_wdata[AW-1:0];
        default:   count_q <= cfg_wdata[CW-1:0];
      endcase
    end
  end

endmodule

// File: rtl/dma_xfer_cnt.sv
module dma_xfer_cnt #(
  parameter int AW = 16,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] load_addr,
  input  logic [CW-1:0] load_count,
  input  logic          step,
  output logic [AW-1:0] cur_addr,
  output logic          last
);

  localparam logic [CW-1:0] ONE_LEFT = CW'(1);

  logic [CW-1:0] remain;

  assign last = (remain == ONE_LEFT);

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_addr <= '0;
      remain   <= '0;
    end else if (load) begin
      cur_addr <= load_addr;
      remain   <= load_count;
    end else if (step) begin
      cur_addr <= cur_addr + AW'(1);
      remain   <= remain - ONE_LEFT;
    end
  end

endmodule

// File: rtl/dma_steal_fsm.sv
module dma_steal_fsm
  import dma_steal_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_req,
  input  logic          clr_req,
  input  logic          dir,
  input  logic          count_zero,
  input  logic          last,
  input  logic          per_rdy,
  input  logic [DW-1:0] per_rdata,
  input  logic          bus_gnt,
  input  logic          mem_ready,
  input  logic [DW-1:0] mem_rdata,
  output logic          bus_req,
  output logic          mem_valid,
  output logic          mem_we,
  output logic [DW-1:0] mem_wdata,
  output logic          per_stb,
  output logic [DW-1:0] per_wdata,
  output logic          busy,
  output logic          irq,
  output logic          load,
  output logic          step
);

  steal_state_t state;
  logic         done_set;

  assign load     = (state == ST_IDLE) && start_req && !count_zero;
  assign step     = (state == ST_XFER) && mem_ready;
  assign done_set = ((state == ST_IDLE) && start_req && count_zero) || (step && last);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      bus_req   <= 1'b0;
      mem_valid <= 1'b0;
      mem_we    <= 1'b0;
      mem_wdata <= '0;
      per_stb   <= 1'b0;
      per_wdata <= '0;
      busy      <= 1'b0;
      irq       <= 1'b0;
    end else begin
      per_stb <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (load) begin
            busy  <= 1'b1;
            state <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (per_rdy) begin
            bus_req <= 1'b1;
            state   <= ST_REQ;
          end
        end
        ST_REQ: begin
          if (bus_gnt) begin
            mem_valid <= 1'b1;
            mem_we    <= (dir == DIR_TO_MEM);
            mem_wdata <= per_rdata;
            state     <= ST_XFER;
          end
        end
        ST_XFER: begin
          if (mem_ready) begin
            mem_valid <= 1'b0;
            mem_we    <= 1'b0;
            bus_req   <= 1'b0;
            per_stb   <= 1'b1;
            if (dir == DIR_FROM_MEM) per_wdata <= mem_rdata;
            if (last) begin
              busy  <= 1'b0;
              state <= ST_IDLE;
            end else begin
              state <= ST_REL;
            end
          end
        end
        default: state <= ST_WAIT;
      endcase
      if (done_set)     irq <= 1'b1;
      else if (clr_req) irq <= 1'b0;
    end
  end

endmodule

// File: rtl/dma_steal_top.sv
module dma_steal_top
  import dma_steal_pkg::*;
#(
  parameter int DW  = 16,
  parameter int AW  = 16,
  parameter int PAW = 8,
  parameter int CW  = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cfg_we,
  input  logic [1:0]     cfg_sel,
  input  logic [DW-1:0]  cfg_wdata,
  output logic           busy,
  output logic           irq,
  output logic           bus_req,
  input  logic           bus_gnt,
  output logic           mem_valid,
  output logic           mem_we,
  output logic [AW-1:0]  mem_addr,
  output logic [DW-1:0]  mem_wdata,
  input  logic [DW-1:0]  mem_rdata,
  input  logic           mem_ready,
  output logic [PAW-1:0] per_addr,
  input  logic           per_rdy,
  input  logic [DW-1:0]  per_rdata,
  output logic [DW-1:0]  per_wdata,
  output logic           per_stb
);

  logic          dir_q;
  logic [AW-1:0] maddr_q;
  logic [CW-1:0] count_q;
  logic          start_req;
  logic          clr_req;
  logic          last;
  logic          load;
  logic          step;

  dma_cfg_regs #(.DW(DW), .AW(AW), .PAW(PAW), .CW(CW)) regs_i (
    .clk       (clk),
    .rst       (rst),
    .cfg_we    (cfg_we),
    .cfg_sel   (cfg_sel),
    .cfg_wdata (cfg_wdata),
    .busy      (busy),
    .dir_q     (dir_q),
    .paddr_q   (per_addr),
    .maddr_q   (maddr_q),
    .count_q   (count_q),
    .start_req (start_req),
    .clr_req   (clr_req)
  );

  dma_xfer_cnt #(.AW(AW), .CW(CW)) cnt_i (
    .clk        (clk),
    .rst        (rst),
    .load       (load),
    .load_addr  (maddr_q),
    .load_count (count_q),
    .step       (step),
    .cur_addr   (mem_addr),
    .last       (last)
  );

  dma_steal_fsm #(.DW(DW)) fsm_i (
    .clk        (clk),
    .rst        (rst),
    .start_req  (start_req),
    .clr_req    (clr_req),
    .dir        (dir_q),
    .count_zero (count_q == '0),
    .last       (last),
    .per_rdy    (per_rdy),
    .per_rdata  (per_rdata),
    .bus_gnt    (bus_gnt),
    .mem_ready  (mem_ready),
    .mem_rdata  (mem_rdata),
    .bus_req    (bus_req),
    .mem_valid  (mem_valid),
    .mem_we     (mem_we),
    .mem_wdata  (mem_wdata),
    .per_stb    (per_stb),
    .per_wdata  (per_wdata),
    .busy       (busy),
    .irq        (irq),
    .load       (load),
    .step       (step)
  );

endmodule

// File: rtl/dma_steal_chk.sv
module dma_steal_chk #(
  parameter int DW = 16,
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          cfg_we,
  input logic [1:0]    cfg_sel,
  input logic [DW-1:0] cfg_wdata,
  input logic          busy,
  input logic          irq,
  input logic          bus_req,
  input logic          bus_gnt,
  input logic          mem_valid,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_wdata,
  input logic          mem_ready,
  input logic          per_rdy,
  input logic          per_stb
);

  logic clr_wr;
  assign clr_wr = cfg_we && (cfg_sel == 2'd0) && cfg_wdata[2];

  p_req_needs_rdy_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_req) |-> $past(per_rdy));

  p_req_until_gnt_r4: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_gnt && !mem_valid) |=> bus_req);

  p_valid_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && !mem_ready) |=>
      (mem_valid && $stable(mem_addr) && $stable(mem_wdata) && $stable(mem_we)));

  p_valid_owns_bus_r5: assert property (@(posedge clk) disable iff (rst)
    mem_valid |-> bus_req);

  p_one_word_r5: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && mem_ready) |=> (!bus_req && !mem_valid && per_stb));

  p_stb_single_r5: assert property (@(posedge clk) disable iff (rst)
    per_stb |=> !per_stb);

  p_addr_step_r7: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && mem_ready) |=> (mem_addr == AW'($past(mem_addr) + AW'(1))));

  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!bus_req && !mem_valid));

  p_irq_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    (irq && !clr_wr) |=> irq);

endmodule

bind dma_steal_top dma_steal_chk #(.DW(DW), .AW(AW)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .cfg_we    (cfg_we),
  .cfg_sel   (cfg_sel),
  .cfg_wdata (cfg_wdata),
  .busy      (busy),
  .irq       (irq),
  .bus_req   (bus_req),
  .bus_gnt   (bus_gnt),
  .mem_valid (mem_valid),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .mem_ready (mem_ready),
  .per_rdy   (per_rdy),
  .per_stb   (per_stb)
);

// File: tb/dma_steal_tb.sv
module dma_steal_top_tb_top;

  localparam int DW  = 16;
  localparam int AW  = 16;
  localparam int PAW = 8;
  localparam int CW  = 8;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           cfg_we = 1'b0;
  logic [1:0]     cfg_sel = 2'd0;
  logic [DW-1:0]  cfg_wdata = '0;
  logic           busy, irq, bus_req, mem_valid, mem_we, per_stb;
  logic           bus_gnt = 1'b0;
  logic           mem_ready = 1'b0;
  logic [AW-1:0]  mem_addr;
  logic [DW-1:0]  mem_wdata, per_wdata;
  logic [DW-1:0]  mem_rdata = '0;
  logic [PAW-1:0] per_addr;
  logic           per_rdy;
  logic [DW-1:0]  per_rdata;

  logic [DW-1:0] mem [0:255];
  logic [DW-1:0] rx  [0:15];

  int n_checks = 0;
  int n_err    = 0;
  bit finished = 0;

  int gnt_lat = 0, mem_lat = 0, per_lat = 0;
  bit per_block = 0;
  bit rdy_int = 1;
  int pidx = 0;
  int exp_words = 0;
  int req_rises = 0, req_wait = 0, valid_cyc = 0, stb_cnt = 0;

  assign per_rdy   = rdy_int && !per_block;
  assign per_rdata = 16'hA000 + 16'(pidx);

  always #10 clk = ~clk;

  dma_steal_top #(.DW(DW), .AW(AW), .PAW(PAW), .CW(CW)) dut_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .busy(busy), .irq(irq), .bus_req(bus_req), .bus_gnt(bus_gnt),
    .mem_valid(mem_valid), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ready(mem_ready), .per_addr(per_addr),
    .per_rdy(per_rdy), .per_rdata(per_rdata), .per_wdata(per_wdata), .per_stb(per_stb)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Bus, memory and peripheral models plus monitor, all acting at the falling edge.
  initial begin
    int gcnt, mcnt, pcnt;
    bit prev_req;
    gcnt = 0; mcnt = 0; pcnt = 0; prev_req = 0;
    forever begin
      @(negedge clk);
      if (!rst) begin
        if (bus_req && !prev_req) req_rises++;
        if (bus_req && !mem_valid) req_wait++;
        if (mem_valid) valid_cyc++;
        prev_req = bus_req;
        if (per_stb) begin
          if (stb_cnt < 16) rx[stb_cnt] = per_wdata;
          stb_cnt++;
          if (stb_cnt == exp_words)
            chk(irq && !busy, "R8 completion flags at last strobe", {30'd0, irq, busy}, 32'h2);
          else
            chk(busy && !irq, "R8 busy held before last word", {30'd0, irq, busy}, 32'h1);
        end
      end
      if (!bus_req) begin bus_gnt = 0; gcnt = 0; end
      else if (!bus_gnt) begin
        if (gcnt >= gnt_lat) bus_gnt = 1; else gcnt++;
      end
      mem_rdata = mem[mem_addr[7:0]];
      if (mem_valid && !mem_ready) begin
        if (mcnt >= mem_lat) begin
          mem_ready = 1;
          if (mem_we) mem[mem_addr[7:0]] = mem_wdata;
        end else mcnt++;
      end else begin
        mem_ready = 0; mcnt = 0;
      end
      if (per_stb) begin
        pidx++; rdy_int = 0; pcnt = 0;
      end else if (!rdy_int) begin
        if (pcnt >= per_lat) rdy_int = 1; else pcnt++;
      end
    end
  end

  task automatic tick();
    @(negedge clk); #1;
  endtask

  task automatic cfg_write(input logic [1:0] sel, input logic [DW-1:0] data);
    tick();
    cfg_we = 1; cfg_sel = sel; cfg_wdata = data;
    tick();
    cfg_we = 0;
  endtask

  task automatic clear_mon(input int words);
    req_rises = 0; req_wait = 0; valid_cyc = 0; stb_cnt = 0; pidx = 0; exp_words = words;
  endtask

  task automatic wait_irq();
    for (int i = 0; i < 600; i++) begin
      if (irq) return;
      tick();
    end
    chk(0, "R8 transfer did not complete", 0, 1);
  endtask

  task automatic run_one(input bit d, input int words, input int start, input int run);
    for (int k = 0; k < words; k++)
      mem[start + k] = d ? 16'(16'h5000 + run * 16 + k) : 16'h0000;
    mem[start + words] = 16'hDEAD;
    cfg_write(2'd0, 16'h0004);
    clear_mon(words);
    cfg_write(2'd1, 16'(run & 8'hFF));
    cfg_write(2'd2, 16'(start));
    cfg_write(2'd3, 16'(words));
    cfg_write(2'd0, {13'd0, 1'b0, d, 1'b1});
    if (words == 0) begin
      chk(irq && !busy, "R10 zero count completes next cycle", {30'd0, irq, busy}, 32'h2);
      repeat (3) tick();
      chk(req_rises == 0, "R10 zero count takes no bus", req_rises, 0);
      return;
    end
    chk(per_addr == 8'(run & 8'hFF), "R11 peripheral address", per_addr, run & 8'hFF);
    wait_irq();
    tick();
    chk(!busy && irq, "R8 idle and interrupt after block", {30'd0, irq, busy}, 32'h2);
    chk(stb_cnt == words, "R7 word count", stb_cnt, words);
    chk(req_rises == words, "R5 one request per word", req_rises, words);
    chk(req_wait == words * (gnt_lat + 1), "R4 request-to-access cycles", req_wait, words * (gnt_lat + 1));
    chk(valid_cyc == words * (mem_lat + 1), "R4 access held until ready", valid_cyc, words * (mem_lat + 1));
    for (int k = 0; k < words; k++) begin
      if (d == 0)
        chk(mem[start + k] == 16'(16'hA000 + k), "R6 R7 peripheral to memory word",
            mem[start + k], 16'hA000 + k);
      else
        chk(rx[k] == 16'(16'h5000 + run * 16 + k), "R6 R7 memory to peripheral word",
            rx[k], 16'h5000 + run * 16 + k);
    end
    chk(mem[start + words] == 16'hDEAD, "R7 word past end untouched", mem[start + words], 16'hDEAD);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_err++; n_checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
    end
  end

  initial begin
    int run;
    int wl [4];
    wl[0] = 0; wl[1] = 1; wl[2] = 2; wl[3] = 5;
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (3) tick();
    chk({busy, irq, bus_req, mem_valid, per_stb} == 5'b0, "R1 outputs low in reset",
        {busy, irq, bus_req, mem_valid, per_stb}, 0);
    rst = 0;
    tick();
    chk({busy, irq, bus_req, mem_valid, per_stb} == 5'b0, "R1 outputs low after reset",
        {busy, irq, bus_req, mem_valid, per_stb}, 0);

    // R3: request waits for the peripheral.
    per_block = 1;
    clear_mon(1);
    mem[8'h21] = 16'hDEAD;
    cfg_write(2'd2, 16'h0020);
    cfg_write(2'd3, 16'd1);
    cfg_write(2'd0, 16'h0001);
    for (int i = 0; i < 6; i++) begin
      chk(!bus_req && busy, "R3 no request while peripheral not ready", {30'd0, bus_req, busy}, 1);
      tick();
    end
    per_block = 0;
    tick();
    chk(bus_req, "R3 request one cycle after ready", bus_req, 1);
    wait_irq();
    chk(mem[8'h20] == 16'hA000, "R6 single word written", mem[8'h20], 16'hA000);

    // R2: configuration locked while busy.
    cfg_write(2'd0, 16'h0004);
    per_block = 1;
    clear_mon(2);
    mem[8'h40] = 16'h0; mem[8'h41] = 16'h0; mem[8'h42] = 16'hDEAD; mem[8'h80] = 16'hBEEF;
    cfg_write(2'd1, 16'h003C);
    cfg_write(2'd2, 16'h0040);
    cfg_write(2'd3, 16'd2);
    cfg_write(2'd0, 16'h0001);
    cfg_write(2'd1, 16'h0011);
    cfg_write(2'd2, 16'h0080);
    cfg_write(2'd3, 16'd9);
    cfg_write(2'd0, 16'h0003);
    chk(per_addr == 8'h3C, "R2 R11 peripheral address locked while busy", per_addr, 8'h3C);
    per_block = 0;
    wait_irq();
    tick();
    chk(stb_cnt == 2, "R2 count locked while busy", stb_cnt, 2);
    chk(mem[8'h40] == 16'hA000 && mem[8'h41] == 16'hA001, "R2 address and direction locked",
        mem[8'h41], 16'hA001);
    chk(mem[8'h80] == 16'hBEEF && mem[8'h42] == 16'hDEAD, "R2 ignored start address untouched",
        mem[8'h80], 16'hBEEF);

    // R9: clear write colliding with completion, then a plain clear.
    cfg_write(2'd0, 16'h0004);
    chk(!irq, "R9 clear drops interrupt", irq, 0);
    mem_lat = 2;
    clear_mon(1);
    cfg_write(2'd2, 16'h0060);
    cfg_write(2'd3, 16'd1);
    cfg_write(2'd0, 16'h0003);
    for (int i = 0; i < 100; i++) begin
      if (mem_ready) break;
      tick();
    end
    cfg_we = 1; cfg_sel = 2'd0; cfg_wdata = 16'h0004;
    tick();
    cfg_we = 0;
    chk(irq && !busy, "R9 completion beats simultaneous clear", {30'd0, irq, busy}, 32'h2);
    repeat (5) tick();
    chk(irq, "R9 interrupt held without clear", irq, 1);
    cfg_write(2'd0, 16'h0004);
    chk(!irq, "R9 later clear drops interrupt", irq, 0);

    // R10: zero count with clear in the same write.
    clear_mon(0);
    cfg_write(2'd3, 16'd0);
    cfg_write(2'd0, 16'h0005);
    chk(irq && !busy, "R10 zero count with clear ends set", {30'd0, irq, busy}, 32'h2);

    // Sweep over direction, length and handshake latencies.
    run = 0;
    for (int d = 0; d < 2; d++)
      for (int wi = 0; wi < 4; wi++)
        for (int gl = 0; gl < 3; gl++)
          for (int ml = 0; ml < 3; ml++)
            for (int pl = 0; pl < 2; pl++) begin
              gnt_lat = gl; mem_lat = ml; per_lat = pl;
              run_one(d[0], wl[wi], (run * 11) % 200 + 8, run);
              run++;
            end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

endmodule